// File: doc/BRIEF.md
# Floating-Point Exception Result Fixup

This block sits after a single-precision arithmetic unit and settles what happens to the result word once the unit has flagged its raw conditions. Those conditions are overflow, underflow, inexact, divide-by-zero and invalid. The block also derives a sixth condition, the unimplemented case, for an underflow that can be neither trapped nor flushed. It then picks one of four outcomes:

- pass the candidate word through;
- substitute the largest finite magnitude;
- substitute infinity;
- substitute a signed zero.

When any armed condition is present it suppresses the destination write and raises a trap request instead.

Output timing is as follows:

- Result, write enable and trap request are combinational. They are valid in the same cycle as the operation strobe.
- The cause flags are sticky register bits. They take the effect of an operation at the following clock edge and stay set until a synchronous clear.

Top module: `fp_exc_fixup`

## Requirements
- R1: With overflow masked (trapEnable[2]=0), rounding mode 2'b00 (nearest) writes infinity of the result sign: 0x7F800000 for a positive result, 0xFF800000 for a negative one. Rounding mode 2'b01 (toward zero) writes the largest finite value of the result sign: 0x7F7FFFFF or 0xFF7FFFFF.
- R2: With overflow masked, rounding mode 2'b10 (toward plus infinity) writes 0x7F800000 for a positive result and 0xFF7FFFFF for a negative one. Rounding mode 2'b11 (toward minus infinity) writes 0x7F7FFFFF for a positive result and 0xFF800000 for a negative one.
- R3: A masked overflow also sets the inexact cause flag (causeFlags[4]) as well as the overflow flag (causeFlags[2]).
- R4: The trap enables are trapEnable bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow and 4 inexact. When a condition is present and its enable bit is 1, trapReq is high and outWrite is low in that cycle.
- R5: An underflow with trapEnable[3]=0 and denormZero=0 is unimplemented. It sets causeFlags[5], raises trapReq and suppresses outWrite whatever the enable bits hold.
- R6: An underflow with trapEnable[3]=0 and denormZero=1 writes zero carrying the result sign (0x00000000 or 0x80000000).
- R7: When no armed condition is present and no substitution applies, candResult is written unchanged with outWrite high and trapReq low.
- R8: causeFlags hold bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact and 5 unimplemented. Each bit sets at the clock edge ending a valid operation that detected the condition and stays set until stickyClr. A clear in the same cycle as a valid operation drops the old bits but keeps the new ones.
- R9: While opValid is low, outWrite and trapReq stay low and causeFlags do not change, whatever the raw condition inputs hold.
- R10: After reset causeFlags is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| resSign | input | 1 | Sign of the exact result |
| rawOvf | input | 1 | Raw overflow from the datapath |
| rawUdf | input | 1 | Raw underflow from the datapath |
| rawInexact | input | 1 | Raw inexact from the datapath |
| rawDivZero | input | 1 | Raw divide-by-zero |
| rawInvalid | input | 1 | Raw invalid operation |
| rndMode | input | 2 | Rounding mode (00 near, 01 zero, 10 up, 11 down) |
| trapEnable | input | 5 | Per-condition trap enables |
| denormZero | input | 1 | Flush masked underflow to zero when 1 |
| candResult | input | 32 | Candidate result word |
| stickyClr | input | 1 | Synchronous clear of the cause flags |
| outResult | output | 32 | Final result word |
| outWrite | output | 1 | Destination write enable |
| trapReq | output | 1 | Exception trap request |
| causeFlags | output | 6 | Sticky cause flags |

## Verification
Two functions can land in the same clock edge: the software clear of the sticky flags and the setting of new flags by a valid operation. The bench first builds up several flags, then issues a masked overflow with stickyClr held high in the same cycle. It expects exactly the overflow and inexact bits afterwards, with no survivor from before the clear. A masked overflow is also a second coincidence, because it sets two cause bits and substitutes a result at once. Both effects are judged in the same sampled cycle.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NCAUSE = 6;
  localparam int C_INV = 0;
  localparam int C_DZ  = 1;
  localparam int C_OVF = 2;
  localparam int C_UDF = 3;
  localparam int C_INX = 4;
  localparam int C_UNI = 5;
  localparam int NEN   = NCAUSE - 1;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_UP   = 2'b10,
    RND_DOWN = 2'b11
  } rnd_e;

  typedef enum logic [1:0] {
    FIX_PASS = 2'd0,
    FIX_INF  = 2'd1,
    FIX_MAX  = 2'd2,
    FIX_ZERO = 2'd3
  } fix_e;

  typedef struct packed {
    fix_e              fixSel;
    logic              wrEn;
    logic              trap;
    logic [NCAUSE-1:0] setMask;
  } strobe_t;
endpackage

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
  import fpx_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           opValid,
  input  logic           resSign,
  input  logic           rawOvf,
  input  logic           rawUdf,
  input  logic           rawInexact,
  input  logic           rawDivZero,
  input  logic           rawInvalid,
  input  logic [1:0]     rndMode,
  input  logic [NEN-1:0] trapEnable,
  input  logic           denormZero,
  output strobe_t        strobe
);
  logic              ovfMasked;
  logic              udfMasked;
  logic              unimpl;
  logic              useInf;
  logic              trapAny;
  logic [NCAUSE-1:0] cause;
  logic [NCAUSE-1:0] armed;
  rnd_e              mode;

  assign mode      = rnd_e'(rndMode);
  assign ovfMasked = rawOvf & ~trapEnable[C_OVF];
  assign udfMasked = rawUdf & ~trapEnable[C_UDF];
  assign unimpl    = udfMasked & ~denormZero;

  always_comb begin
    cause        = '0;
    cause[C_INV] = rawInvalid;
    cause[C_DZ]  = rawDivZero;
    cause[C_OVF] = rawOvf;
    cause[C_UDF] = rawUdf;
    cause[C_INX] = rawInexact | ovfMasked;
    cause[C_UNI] = unimpl;
  end

  // Enabled conditions arm a trap; the unimplemented case always does.
  for (genvar i = 0; i < NCAUSE; i++) begin : g_arm
    if (i == C_UNI) begin : g_always
      assign armed[i] = cause[i];
    end else begin : g_gated
      assign armed[i] = cause[i] & trapEnable[i];
    end
  end

  assign trapAny = |armed;

  always_comb begin
    unique case (mode)
      RND_NEAR: useInf = 1'b1;
      RND_ZERO: useInf = 1'b0;
      RND_UP:   useInf = ~resSign;
      RND_DOWN: useInf = resSign;
      default:  useInf = 1'b1;
    endcase
  end

  always_comb begin
    strobe.fixSel  = FIX_PASS;
    if (ovfMasked)
      strobe.fixSel = useInf ? FIX_INF : FIX_MAX;
    else if (udfMasked && denormZero)
      strobe.fixSel = FIX_ZERO;
    strobe.wrEn    = opValid & ~trapAny;
    strobe.trap    = opValid & trapAny;
    strobe.setMask = opValid ? cause : '0;
  end

  // R4: an enabled condition on a valid op always requests a trap
  a_r4_enabled_traps: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && ((rawOvf && trapEnable[C_OVF]) || (rawDivZero && trapEnable[C_DZ])
      || (rawInvalid && trapEnable[C_INV]))) |-> (strobe.trap && !strobe.wrEn));

  // R5: masked underflow without flush always traps
  a_r5_unimpl_trap: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && rawUdf && !trapEnable[C_UDF] && !denormZero) |-> (strobe.trap && !strobe.wrEn));

  // R9: no activity without the operation strobe
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> (!strobe.trap && !strobe.wrEn && strobe.setMask == '0));
endmodule

// File: rtl/fpx_datapath.sv
module fpx_datapath
  import fpx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              resSign,
  input  logic [DATA_W-1:0] candResult,
  input  logic              stickyClr,
  output logic [DATA_W-1:0] outResult,
  output logic [NCAUSE-1:0] causeFlags
);
  localparam int FRAC_W = DATA_W - 1 - EXP_W;
  localparam logic [DATA_W-2:0] MAG_INF = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [DATA_W-2:0] MAG_MAX = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};

  logic [NCAUSE-1:0] flagsQ;
  logic [NCAUSE-1:0] flagsD;

  always_comb begin
    unique case (strobe.fixSel)
      FIX_INF:  outResult = {resSign, MAG_INF};
      FIX_MAX:  outResult = {resSign, MAG_MAX};
      FIX_ZERO: outResult = {resSign, {(DATA_W-1){1'b0}}};
      default:  outResult = candResult;
    endcase
  end

  assign flagsD = (stickyClr ? '0 : flagsQ) | strobe.setMask;

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagsD;
  end

  assign causeFlags = flagsQ;

  // R8: without a clear, no flag ever drops
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stickyClr |=> ((causeFlags & $past(causeFlags)) == $past(causeFlags)));

  // R6: a flush never yields a nonzero magnitude
  a_r6_flush_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fixSel == FIX_ZERO) |-> (outResult[DATA_W-2:0] == '0));

  // R1: a substituted overflow value always has an all-ones-top exponent
  a_r1_ovf_exp: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fixSel == FIX_INF || strobe.fixSel == FIX_MAX)
      |-> (outResult[DATA_W-2 -: EXP_W-1] == '1 && outResult[DATA_W-1] == resSign));
endmodule

// File: rtl/fp_exc_fixup.sv
module fp_exc_fixup
  import fpx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic              resSign,
  input  logic              rawOvf,
  input  logic              rawUdf,
  input  logic              rawInexact,
  input  logic              rawDivZero,
  input  logic              rawInvalid,
  input  logic [1:0]        rndMode,
  input  logic [4:0]        trapEnable,
  input  logic              denormZero,
  input  logic [DATA_W-1:0] candResult,
  input  logic              stickyClr,
  output logic [DATA_W-1:0] outResult,
  output logic              outWrite,
  output logic              trapReq,
  output logic [5:0]        causeFlags
);
  strobe_t strobe;

  fpx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .resSign    (resSign),
    .rawOvf     (rawOvf),
    .rawUdf     (rawUdf),
    .rawInexact (rawInexact),
    .rawDivZero (rawDivZero),
    .rawInvalid (rawInvalid),
    .rndMode    (rndMode),
    .trapEnable (trapEnable),
    .denormZero (denormZero),
    .strobe     (strobe)
  );

  fpx_datapath #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .resSign    (resSign),
    .candResult (candResult),
    .stickyClr  (stickyClr),
    .outResult  (outResult),
    .causeFlags (causeFlags)
  );

  assign outWrite = strobe.wrEn;
  assign trapReq  = strobe.trap;

  // R4: a trap and a write never coincide
  a_r4_trap_no_write: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> !outWrite);

  // R3: masked overflow leaves the inexact flag set
  a_r3_ovf_inexact: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && rawOvf && !trapEnable[2]) |=> causeFlags[4]);

  // R7: an unflagged op writes the candidate untouched
  a_r7_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !rawOvf && !rawUdf && !rawInexact && !rawDivZero && !rawInvalid)
      |-> (outWrite && outResult == candResult));
endmodule

// File: tb/tb_fp_exc_fixup.sv
`timescale 1ns/1ps
module tb_fp_exc_fixup;
  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic        tr;
    logic [5:0]  fl;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0, resSign = 1'b0;
  logic        rawOvf = 1'b0, rawUdf = 1'b0, rawInexact = 1'b0, rawDivZero = 1'b0, rawInvalid = 1'b0;
  logic [1:0]  rndMode = 2'b00;
  logic [4:0]  trapEnable = 5'b0;
  logic        denormZero = 1'b0;
  logic [31:0] candResult = 32'h0;
  logic        stickyClr = 1'b0;
  logic [31:0] outResult;
  logic        outWrite, trapReq;
  logic [5:0]  causeFlags;

  int checks = 0;
  int errors = 0;
  exp_t sbq[$];
  logic [5:0] modelFlags = 6'b0;
  bit done = 0;

  always #2 clk = ~clk;

  fp_exc_fixup dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .resSign(resSign),
    .rawOvf(rawOvf), .rawUdf(rawUdf), .rawInexact(rawInexact),
    .rawDivZero(rawDivZero), .rawInvalid(rawInvalid), .rndMode(rndMode),
    .trapEnable(trapEnable), .denormZero(denormZero), .candResult(candResult),
    .stickyClr(stickyClr), .outResult(outResult), .outWrite(outWrite),
    .trapReq(trapReq), .causeFlags(causeFlags)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Drive one cycle and push the expected outcome derived from the requirements.
  task automatic drive(input bit v, input bit s, input bit ov, input bit ud, input bit ix,
                       input bit dz, input bit iv, input logic [1:0] rm, input logic [4:0] en,
                       input bit dn, input logic [31:0] cand, input bit clr, input string tag);
    exp_t e;
    logic [5:0] c;
    bit mOvf, mUdf, uni, armed;
    @(negedge clk);
    opValid = v; resSign = s; rawOvf = ov; rawUdf = ud; rawInexact = ix;
    rawDivZero = dz; rawInvalid = iv; rndMode = rm; trapEnable = en;
    denormZero = dn; candResult = cand; stickyClr = clr;
    mOvf = ov && !en[2];
    mUdf = ud && !en[3];
    uni  = mUdf && !dn;
    c = {uni, ix || mOvf, ud, ov, dz, iv};
    armed = uni || (|(c[4:0] & en));
    e.tr = v && armed;
    e.wr = v && !armed;
    if (mOvf) begin
      case (rm)
        2'b00: e.res = s ? 32'hFF800000 : 32'h7F800000;
        2'b01: e.res = s ? 32'hFF7FFFFF : 32'h7F7FFFFF;
        2'b10: e.res = s ? 32'hFF7FFFFF : 32'h7F800000;
        default: e.res = s ? 32'hFF800000 : 32'h7F7FFFFF;
      endcase
    end else if (mUdf && dn) e.res = {s, 31'b0};
    else e.res = cand;
    modelFlags = (clr ? 6'b0 : modelFlags) | (v ? c : 6'b0);
    e.fl = modelFlags;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // Monitor: sample one time unit after each rising edge.
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        check(outWrite === e.wr, {e.tag, " write"}, {31'b0, outWrite}, {31'b0, e.wr});
        check(trapReq === e.tr, {e.tag, " trap"}, {31'b0, trapReq}, {31'b0, e.tr});
        if (e.wr) check(outResult === e.res, {e.tag, " result"}, outResult, e.res);
        check(causeFlags === e.fl, {e.tag, " flags"}, {26'b0, causeFlags}, {26'b0, e.fl});
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: flags clear after reset
    check(causeFlags === 6'b0, "R10 reset flags", {26'b0, causeFlags}, 32'h0);
    check(outWrite === 1'b0, "R10 idle write", {31'b0, outWrite}, 32'h0);

    drive(1,0,0,0,0,0,0,2'b00,5'b00000,0,32'h3F800000,0,"R7 clean pass");
    drive(1,1,0,0,1,0,0,2'b01,5'b00000,0,32'hC0490FDB,0,"R7 masked inexact pass");
    drive(1,0,0,0,0,0,1,2'b00,5'b00000,0,32'h7FC00000,0,"R7 masked invalid pass");
    drive(1,0,1,0,1,0,0,2'b00,5'b00000,0,32'h12345678,1,"R1 near pos");
    drive(1,1,1,0,1,0,0,2'b00,5'b00000,0,32'h12345678,0,"R1 near neg");
    drive(1,0,1,0,0,0,0,2'b01,5'b00000,0,32'h12345678,0,"R1 zero pos");
    drive(1,1,1,0,0,0,0,2'b01,5'b00000,0,32'h12345678,0,"R1 zero neg");
    drive(1,0,1,0,0,0,0,2'b10,5'b00000,0,32'h0,1,"R2 up pos R3");
    drive(1,1,1,0,0,0,0,2'b10,5'b00000,0,32'h0,0,"R2 up neg");
    drive(1,0,1,0,0,0,0,2'b11,5'b00000,0,32'h0,0,"R2 down pos");
    drive(1,1,1,0,0,0,0,2'b11,5'b00000,0,32'h0,0,"R2 down neg");
    drive(1,0,1,0,1,0,0,2'b00,5'b00100,0,32'h0,1,"R4 ovf enabled");
    drive(1,0,0,1,0,0,0,2'b00,5'b01000,0,32'h0,0,"R4 udf enabled");
    drive(1,0,0,0,0,1,0,2'b00,5'b00010,0,32'h0,0,"R4 divzero enabled");
    drive(1,0,0,0,1,0,0,2'b00,5'b10000,0,32'h0,0,"R4 inexact enabled");
    drive(1,0,0,1,1,0,0,2'b00,5'b00000,0,32'h00000001,1,"R5 unimpl no enables");
    drive(1,1,0,1,0,0,0,2'b00,5'b10111,0,32'h00000001,0,"R5 unimpl other enables");
    drive(1,0,0,1,1,0,0,2'b00,5'b00000,1,32'h00000003,1,"R6 flush pos");
    drive(1,1,0,1,1,0,0,2'b00,5'b00000,1,32'h80000003,0,"R6 flush neg");
    drive(0,1,1,1,1,1,1,2'b00,5'b11111,0,32'hDEADBEEF,0,"R9 idle raw");
    drive(0,0,1,0,0,0,0,2'b00,5'b00000,0,32'h0,0,"R9 idle masked ovf");
    drive(1,0,0,0,0,1,1,2'b00,5'b00000,0,32'h0,0,"R8 build flags");
    drive(0,0,0,0,0,0,0,2'b00,5'b00000,0,32'h0,0,"R8 hold");
    drive(0,0,0,0,0,0,0,2'b00,5'b00000,0,32'h0,1,"R8 clear alone");
    drive(1,0,0,0,0,1,1,2'b00,5'b00000,0,32'h0,0,"R8 rebuild");
    drive(1,1,1,0,0,0,0,2'b01,5'b00000,0,32'h0,1,"R8 clear with set R3");
    drive(0,0,0,0,0,0,0,2'b00,5'b00000,0,32'h0,0,"R8 after clear");

    @(negedge clk);
    opValid = 1'b0; stickyClr = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule